// File: doc/BRIEF.md
# One-Time-Programmable Byte Store with Pin-Mode Control

This block is a synthesizable behavioural model of a byte-wide programmable read-only memory and the logic that turns its control pins into operating modes. A chip-select/program strobe, an output-enable, a programming-voltage flag and a high-voltage identifier flag together choose between reading, standby, programming, program-verify and identifier readout. The full part holds 2^19 bytes. The default depth is smaller so that simulation stays fast.

Programming can only pull bits from 1 to 0. When a program strobe ends, the stored byte becomes the AND of its old value and the data input. A bulk erase input returns every byte to all ones. It does this by sweeping the array one address per clock, and a busy flag stays high for the whole sweep. In identifier mode the block returns one of two fixed code bytes, chosen by the lowest address bit. Each code byte carries odd parity in its top bit.

The data output has its own drive-enable signal. A surrounding bench or board model uses it to check tri-state behaviour.

Top module: `otp_byte_store`

## Requirements
- R1: After an erase request is seen at a clock edge while idle, `erase_busy` stays high for exactly DEPTH clock cycles. It writes one address per clock. Afterwards every byte reads 8'hFF.
- R2: A program write happens on the clock edge where `cs_n` is sampled high after being sampled low, with `vpp_hi`=1 and `oe_n`=1. The stored byte becomes the old byte AND `din`, so no bit ever changes from 0 to 1.
- R3: In read mode (`cs_n`=0, `oe_n`=0, `vpp_hi`=0, identifier mode not selected), `dout_en`=1 and `dout` shows the byte stored at `addr`.
- R4: When `cs_n`=1 and `vpp_hi`=0, `dout_en`=0 and `dout`=8'h00, whatever the value of `oe_n`.
- R5: With `vpp_hi`=1, `oe_n`=1 and `cs_n` held high, the array is not changed. A `cs_n` pulse while `oe_n`=0 writes nothing either.
- R6: In program-verify mode (`vpp_hi`=1, `oe_n`=0, `cs_n`=1), `dout_en`=1 and `dout` shows the byte stored at `addr`.
- R7: In read mode with `id_hv`=1 and `addr[ADDR_W-1:1]`=0, `dout` is the manufacturer byte when `addr[0]`=0 and the device byte when `addr[0]`=1. Each byte is {parity, 7-bit code parameter}, with the parity bit chosen so that the byte holds an odd number of ones. With `id_hv`=1 and any upper address bit set, the array byte is read instead.
- R8: While `erase_busy`=1, `dout_en`=0, program strobes are ignored, and a new erase request does not restart or lengthen the sweep.
- R9: With `cs_n`=0, `oe_n`=1 and `vpp_hi`=0, `dout_en`=0.
- R10: After reset, `erase_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low; also the program strobe |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage present |
| id_hv | input | 1 | High-voltage identifier flag |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| erase_req | input | 1 | Start a bulk erase sweep |
| dout | output | 8 | Output data, 0 when not driven |
| dout_en | output | 1 | Output drive enable |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The assertions check on every cycle that:
- the output is never driven without the enables, nor during standby or an erase sweep;
- identifier bytes always have odd parity;
- a program write never sets a bit;
- the sweep starts at address zero, ends on the last address, and blocks program writes while it runs.

Only the bench's scenarios can show the values themselves: that a programmed byte reads back as the AND of old and new data, that inhibited strobes leave the array unchanged, that the sweep lasts exactly DEPTH cycles, and that the identifier codes and the array bytes appear in the right modes.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_IDENT,
        M_PROGRAM,
        M_VERIFY,
        M_QUIET,
        M_BUSY
    } mode_e;

    // top bit makes the total count of ones odd
    function automatic logic [7:0] odd_byte(input logic [6:0] code);
        return {~^code, code};
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output mode_e             mode
);

    logic upper_zero;

    always_comb begin
        upper_zero = (addr[ADDR_W-1:1] == '0);
        if (busy)
            mode = M_BUSY;
        else if (vpp_hi && oe_n)
            mode = M_PROGRAM;
        else if (vpp_hi && cs_n && !oe_n)
            mode = M_VERIFY;
        else if (!vpp_hi && !cs_n && !oe_n)
            mode = (id_hv && upper_zero) ? M_IDENT : M_READ;
        else if (cs_n)
            mode = M_STANDBY;
        else
            mode = M_QUIET;
    end

endmodule

// File: rtl/otp_id_gen.sv
module otp_id_gen
    import otp_pkg::*;
#(
    parameter logic [6:0] MFR_CODE = 7'h01,
    parameter logic [6:0] DEV_CODE = 7'h1B
) (
    input  logic       sel_dev,
    input  logic       active,
    output logic [7:0] code
);

    localparam logic [7:0] MFR_BYTE = odd_byte(MFR_CODE);
    localparam logic [7:0] DEV_BYTE = odd_byte(DEV_CODE);

    always_comb code = sel_dev ? DEV_BYTE : MFR_BYTE;

    // R7: any identifier byte on the bus holds an odd number of ones
    a_r7_odd_parity: assert property (@(posedge active) 1'b1 |-> ($countones(code) % 2) == 1);

endmodule

// File: rtl/otp_erase_seq.sv
module otp_erase_seq #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] ptr;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.ptr == LAST) begin
                s_d.busy = 1'b0;
                s_d.ptr  = '0;
            end else begin
                s_d.ptr = s_q.ptr + 1'b1;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.ptr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign wr_en   = s_q.busy;
    assign wr_addr = s_q.ptr;

    // R1: sweep starts at address zero
    a_r1_sweep_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> s_q.ptr == '0);
    // R1: sweep finishes right after the final address
    a_r1_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.ptr == LAST) |=> !s_q.busy);
    // R8: a request during a sweep does not rewind the pointer
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.ptr != LAST) |=> s_q.ptr == $past(s_q.ptr) + 1'b1);

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
    import otp_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [6:0] MFR_CODE = 7'h01,
    parameter logic [6:0] DEV_CODE = 7'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              erase_req,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              erase_busy
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic cs_n;
    } strobe_t;

    strobe_t     st_d, st_q;
    mode_e       mode;
    logic        ers_we;
    logic [ADDR_W-1:0] ers_addr;
    logic        prog_we;
    logic [7:0]  rd_word;
    logic [7:0]  id_code;
    logic [7:0]  mem_q [DEPTH];

    otp_mode_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cs_n   (cs_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .addr   (addr),
        .busy   (erase_busy),
        .mode   (mode)
    );

    otp_erase_seq #(.ADDR_W(ADDR_W)) u_erase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (erase_req),
        .busy    (erase_busy),
        .wr_en   (ers_we),
        .wr_addr (ers_addr)
    );

    otp_id_gen #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .sel_dev (addr[0]),
        .active  (mode == M_IDENT),
        .code    (id_code)
    );

    always_comb begin
        st_d.cs_n = cs_n;
        rd_word   = mem_q[addr];
        prog_we   = (mode == M_PROGRAM) && cs_n && !st_q.cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs_n: 1'b1};
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (ers_we)
            mem_q[ers_addr] <= 8'hFF;
        else if (prog_we)
            mem_q[addr] <= rd_word & din;
    end

    always_comb begin
        dout_en = 1'b0;
        dout    = 8'h00;
        unique case (mode)
            M_READ, M_VERIFY: begin
                dout_en = 1'b1;
                dout    = rd_word;
            end
            M_IDENT: begin
                dout_en = 1'b1;
                dout    = id_code;
            end
            default: ;
        endcase
    end

    // R2: a program write never raises a bit
    a_r2_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> (mem_q[$past(addr)] & ~$past(rd_word)) == 8'h00);
    // R4: standby keeps the bus released
    a_r4_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !vpp_hi) |-> !dout_en);
    // R8: no drive and no program write during a sweep
    a_r8_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> (!dout_en && !prog_we));
    // R9: drive only with output enable asserted
    a_r9_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !oe_n);

endmodule

// File: tb/otp_byte_store_bench.sv
module otp_byte_store_bench;

    localparam int         ADDR_W = 8;
    localparam int         DEPTH  = 1 << ADDR_W;
    localparam logic [6:0] MFR    = 7'h01;
    localparam logic [6:0] DEV    = 7'h1B;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = 8'h00;
    logic              erase_req = 1'b0;
    logic [7:0]        dout;
    logic              dout_en;
    logic              erase_busy;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    otp_byte_store #(.ADDR_W(ADDR_W), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_otp_byte_store (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .id_hv(id_hv), .addr(addr), .din(din), .erase_req(erase_req),
        .dout(dout), .dout_en(dout_en), .erase_busy(erase_busy)
    );

    function automatic logic [7:0] id_byte(input logic [6:0] c);
        int n = 0;
        for (int i = 0; i < 7; i++) n += c[i];
        return {(n % 2 == 0), c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pins_idle();
        cs_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b0; erase_req = 1'b0;
    endtask

    task automatic program_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; vpp_hi = 1'b1; oe_n = 1'b1; cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        pins_idle();
        model[a] = model[a] & d;
    endtask

    task automatic read_check(input string req, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        addr = a; vpp_hi = 1'b0; cs_n = 1'b0; oe_n = 1'b0;
        #1;
        check(req, {dout_en, dout}, {1'b1, model[a]});
        pins_idle();
    endtask

    task automatic verify_check(input string req, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        addr = a; vpp_hi = 1'b1; cs_n = 1'b1; oe_n = 1'b0;
        #1;
        check(req, {dout_en, dout}, {1'b1, model[a]});
        pins_idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int cnt;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {erase_busy, dout_en}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", erase_busy, 1'b0);

        // R1 / R8: erase sweep with disturbances
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        cnt = 0;
        while (erase_busy && cnt < DEPTH + 20) begin
            cnt++;
            case (cnt)
                5:  begin addr = '0; din = 8'h00; vpp_hi = 1'b1; oe_n = 1'b1; cs_n = 1'b0; end
                6:  cs_n = 1'b1;
                8:  begin pins_idle(); erase_req = 1'b1; end
                9:  erase_req = 1'b0;
                10: begin cs_n = 1'b0; oe_n = 1'b0; end
                11: begin #1; check("R8", dout_en, 1'b0); pins_idle(); end
                default: ;
            endcase
            @(negedge clk);
        end
        check("R1", cnt, DEPTH);
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        read_check("R8", 0);
        read_check("R1", DEPTH - 1);
        read_check("R1", 8'h5A);

        // R2: AND semantics
        program_byte(8'h10, 8'hF0);
        read_check("R2", 8'h10);
        program_byte(8'h10, 8'h3C);
        read_check("R2", 8'h10);
        program_byte(8'h10, 8'hFF);
        read_check("R2", 8'h10);

        // R5: inhibited device (cs_n held high)
        @(negedge clk);
        addr = 8'h20; din = 8'h00; vpp_hi = 1'b1; oe_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        pins_idle();
        read_check("R5", 8'h20);
        // R5: strobe with oe_n low writes nothing
        @(negedge clk);
        addr = 8'h21; din = 8'h00; vpp_hi = 1'b1; oe_n = 1'b0; cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        pins_idle();
        read_check("R5", 8'h21);

        // R6: verify
        program_byte(8'h30, 8'hA5);
        verify_check("R6", 8'h30);

        // R4: standby regardless of oe_n
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b0; addr = 8'h30;
        #1;
        check("R4", {dout_en, dout}, 9'h000);
        oe_n = 1'b1;
        #1;
        check("R4", {dout_en, dout}, 9'h000);
        // R9: selected but output disabled
        cs_n = 1'b0;
        #1;
        check("R9", dout_en, 1'b0);
        pins_idle();

        // R7: identifier bytes
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; id_hv = 1'b1; addr = 8'h00;
        #1;
        check("R7", {dout_en, dout}, {1'b1, id_byte(MFR)});
        addr = 8'h01;
        #1;
        check("R7", {dout_en, dout}, {1'b1, id_byte(DEV)});
        addr = 8'h31;
        #1;
        check("R7", {dout_en, dout}, {1'b1, model[8'h31]});
        pins_idle();

        // R3 / R2 / R6: constrained random mix
        for (int k = 0; k < 300; k++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom_range(0, DEPTH - 1));
            case ($urandom_range(0, 2))
                0: program_byte(a, 8'($urandom));
                1: read_check("R3", a);
                default: verify_check("R6", a);
            endcase
        end
        for (int i = 0; i < DEPTH; i += 17) read_check("R2", ADDR_W'(i));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule